// File: doc/BRIEF.md
# Mixed-Width Simple Dual-Port RAM

This block is a RAM with one write port and one read port that reach the same bit storage at different data widths. A wide writer can feed a narrow reader, for example eight bits in and two bits out. A narrow writer can also feed a wide reader. The narrow side sees the wide word as a run of sub-words with the least significant slice at the lowest narrow address. Read and write inputs are captured in registers. An optional extra register follows the read data.

The read port has a read enable. While the enable is low, the output holds its value. The enable register clears to the enabled state, so the first clock after reset performs a read. When both ports share one clock, a parameter sets what a read returns if it hits bits that are being written in the same cycle. The choice is either the contents before the write, or an all-ones poison word that marks the data as untrustworthy. When the ports run on unrelated clocks, no collision detection is done and such a read is unspecified.

Top module: `msdp_ram`

## Requirements
- R1: With write width WR_W and read width RD_W, a write to address W stores its data in storage bits [W*WR_W +: WR_W], and a read of address R returns storage bits [R*RD_W +: RD_W]. With 8-bit writes and 2-bit reads, narrow address 0 returns bits [1:0] of wide word 0 and narrow address 3 returns bits [7:6].
- R2: With 8-bit writes and 2-bit reads, writing 8'b00000001 to wide address 0 reads back as 2'b01, 2'b00, 2'b00, 2'b00 at narrow addresses 0, 1, 2, 3.
- R3: With 2-bit writes and 8-bit reads, the four narrow writes at addresses 4k to 4k+3 make up wide word k, and address 4k lands in bits [1:0].
- R4: Read inputs sampled at rising edge n show at rd_data after edge n+1 when OUT_REG is 0, and after edge n+2 when OUT_REG is 1. Before that, rd_data keeps its earlier value.
- R5: A write sampled at one edge is seen by any read whose inputs are sampled at a later edge.
- R6: If rd_en is low at a sampling edge, rd_data does not change as a result of that sample, whatever rd_addr is.
- R7: While reset is asserted, rd_data is 0. The read-enable register resets to enabled and the read address register resets to 0, so the first edge after reset release reads narrow address 0 even if the rd_en port is low.
- R8: In old-data mode with a common clock, a read whose bit span overlaps a write sampled at the same edge returns the contents from before that write.
- R9: In poison mode with a common clock, such an overlapping read returns all ones.
- R10: A sample with wr_en low leaves the storage unchanged, whatever wr_addr and wr_data are.
- R11: A read sampled in the same cycle as a write to bits it does not overlap returns the current stored data, in either collision mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock (tie to wr_clk for a common clock) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| wr_en | input | 1 | Write enable |
| wr_addr | input | WR_AW | Write address in write-width words |
| wr_data | input | WR_W | Write data |
| rd_en | input | 1 | Read enable; low holds rd_data |
| rd_addr | input | RD_AW | Read address in read-width words |
| rd_data | output | RD_W | Read data |

## Verification
The bench checks slice ordering in both directions: every narrow address against a wide word, and every wide word against its narrow parts. A design that packed most-significant-first, or got the address split wrong, would return rotated or swapped slices. It checks same-cycle overlapping reads in both collision modes and a same-cycle read that does not overlap. A design that let the new data through, or poisoned the wrong reads, would fail these. It also checks that a low read enable holds the output, and that the pipeline latency is exact. Last, it resets the block again while the read enable is held low, so that an enable register clearing to disabled would leave rd_data at zero instead of showing word 0.

// File: rtl/msdp_pkg.sv
package msdp_pkg;

  typedef enum logic {
    COLL_OLD    = 1'b0,
    COLL_POISON = 1'b1
  } coll_mode_e;

  // True when bit span [a_lo, a_lo+a_w) meets span [b_lo, b_lo+b_w).
  function automatic logic spans_overlap(input int unsigned a_lo, input int unsigned a_w,
                                         input int unsigned b_lo, input int unsigned b_w);
    return (a_lo < b_lo + b_w) && (b_lo < a_lo + a_w);
  endfunction

endpackage

// File: rtl/msdp_rst_sync.sv
module msdp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sr_q, sr_d;

  always_comb sr_d = {sr_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= 2'b00;
    else        sr_q <= sr_d;
  end

  assign rst_sync_n = sr_q[1];
endmodule

// File: rtl/msdp_wr_side.sv
module msdp_wr_side #(
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          we_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] data_q
);
  logic          we_d;
  logic [AW-1:0] addr_d;
  logic [DW-1:0] data_d;

  always_comb begin
    we_d   = we;
    addr_d = addr;
    data_d = data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      we_q   <= we_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end
endmodule

// File: rtl/msdp_store.sv
module msdp_store #(
  parameter int unsigned TOTAL_BITS = 256,
  parameter int unsigned WR_W       = 8,
  parameter int unsigned RD_W       = 2,
  parameter int unsigned WR_AW      = 5,
  parameter int unsigned RD_AW      = 7
) (
  input  logic             wr_clk,
  input  logic             wr_rst_n,
  input  logic             we_q,
  input  logic [WR_AW-1:0] waddr_q,
  input  logic [WR_W-1:0]  wdata_q,
  input  logic [RD_AW-1:0] raddr_q,
  output logic [RD_W-1:0]  rd_slice
);
  localparam int unsigned BIT_IW = $clog2(TOTAL_BITS);

  logic [TOTAL_BITS-1:0] bits_q, bits_d;
  logic [BIT_IW-1:0]     wr_lsb, rd_lsb;

  assign wr_lsb = BIT_IW'(waddr_q) * BIT_IW'(WR_W);
  assign rd_lsb = BIT_IW'(raddr_q) * BIT_IW'(RD_W);

  always_comb begin
    bits_d = bits_q;
    if (we_q) bits_d[wr_lsb +: WR_W] = wdata_q;
  end

  // Storage array: no reset, like a hard macro.
  always_ff @(posedge wr_clk) begin
    bits_q <= bits_d;
  end

  assign rd_slice = bits_q[rd_lsb +: RD_W];

  p_nowrite_r10: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    !we_q |=> $stable(bits_q));
endmodule

// File: rtl/msdp_rd_side.sv
module msdp_rd_side #(
  parameter int unsigned AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          re,
  input  logic [AW-1:0] addr,
  output logic          re_q,
  output logic [AW-1:0] addr_q
);
  logic          re_d;
  logic [AW-1:0] addr_d;

  always_comb begin
    re_d   = re;
    addr_d = addr;
  end

  // Clearing the enable register leaves reads enabled.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      re_q   <= 1'b1;
      addr_q <= '0;
    end else begin
      re_q   <= re_d;
      addr_q <= addr_d;
    end
  end

  p_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> re_q);
endmodule

// File: rtl/msdp_rd_out.sv
module msdp_rd_out #(
  parameter int unsigned          RD_W      = 2,
  parameter bit                   OUT_REG   = 1'b1,
  parameter msdp_pkg::coll_mode_e COLL_MODE = msdp_pkg::COLL_OLD
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            re_q,
  input  logic            collide,
  input  logic [RD_W-1:0] slice,
  output logic [RD_W-1:0] q
);
  logic [RD_W-1:0] core_q, core_d;
  logic            poison;

  assign poison = collide && (COLL_MODE == msdp_pkg::COLL_POISON);

  always_comb begin
    core_d = core_q;
    if (re_q) core_d = poison ? {RD_W{1'b1}} : slice;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) core_q <= '0;
    else        core_q <= core_d;
  end

  generate
    if (OUT_REG) begin : g_oreg
      logic [RD_W-1:0] pipe_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= core_q;
      end
      assign q = pipe_q;
    end else begin : g_flow
      assign q = core_q;
    end
  endgenerate

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !re_q |=> $stable(core_q));

  p_poison_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (re_q && collide && COLL_MODE == msdp_pkg::COLL_POISON) |=> (core_q == {RD_W{1'b1}}));
endmodule

// File: rtl/msdp_ram.sv
module msdp_ram #(
  parameter int unsigned          TOTAL_BITS = 256,
  parameter int unsigned          WR_W       = 8,
  parameter int unsigned          RD_W       = 2,
  parameter bit                   OUT_REG    = 1'b1,
  parameter bit                   COMMON_CLK = 1'b1,
  parameter msdp_pkg::coll_mode_e COLL_MODE  = msdp_pkg::COLL_OLD,
  localparam int unsigned         WR_AW      = $clog2(TOTAL_BITS / WR_W),
  localparam int unsigned         RD_AW      = $clog2(TOTAL_BITS / RD_W)
) (
  input  logic             wr_clk,
  input  logic             rd_clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WR_AW-1:0] wr_addr,
  input  logic [WR_W-1:0]  wr_data,
  input  logic             rd_en,
  input  logic [RD_AW-1:0] rd_addr,
  output logic [RD_W-1:0]  rd_data
);
  logic             wr_rst_n, rd_rst_n;
  logic             we_q, re_q, collide;
  logic [WR_AW-1:0] waddr_q;
  logic [WR_W-1:0]  wdata_q;
  logic [RD_AW-1:0] raddr_q;
  logic [RD_W-1:0]  slice;

  msdp_rst_sync u_wr_rst (.clk(wr_clk), .rst_n(rst_n), .rst_sync_n(wr_rst_n));
  msdp_rst_sync u_rd_rst (.clk(rd_clk), .rst_n(rst_n), .rst_sync_n(rd_rst_n));

  msdp_wr_side #(.AW(WR_AW), .DW(WR_W)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .we(wr_en), .addr(wr_addr), .data(wr_data),
    .we_q(we_q), .addr_q(waddr_q), .data_q(wdata_q)
  );

  msdp_rd_side #(.AW(RD_AW)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .re(rd_en), .addr(rd_addr),
    .re_q(re_q), .addr_q(raddr_q)
  );

  msdp_store #(
    .TOTAL_BITS(TOTAL_BITS), .WR_W(WR_W), .RD_W(RD_W), .WR_AW(WR_AW), .RD_AW(RD_AW)
  ) u_store (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .we_q(we_q), .waddr_q(waddr_q),
    .wdata_q(wdata_q), .raddr_q(raddr_q), .rd_slice(slice)
  );

  // Collision compare only makes sense when both registers share a clock.
  generate
    if (COMMON_CLK) begin : g_coll
      assign collide = we_q && msdp_pkg::spans_overlap(32'(waddr_q) * WR_W, WR_W,
                                                       32'(raddr_q) * RD_W, RD_W);
    end else begin : g_nocoll
      assign collide = 1'b0;
    end
  endgenerate

  msdp_rd_out #(.RD_W(RD_W), .OUT_REG(OUT_REG), .COLL_MODE(COLL_MODE)) u_out (
    .clk(rd_clk), .rst_n(rd_rst_n), .re_q(re_q), .collide(collide),
    .slice(slice), .q(rd_data)
  );
endmodule

// File: tb/msdp_ram_tb_top.sv
`timescale 1ns/1ps
module msdp_ram_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b1;
  always #2 clk = ~clk;

  // Device A: 8-bit writes, 2-bit reads, old-data, output register.
  logic       a_we, a_re;
  logic [2:0] a_waddr;
  logic [7:0] a_wdata;
  logic [4:0] a_raddr;
  logic [1:0] a_q;
  // Device B: 2-bit writes, 8-bit reads, poison, no output register.
  logic       b_we, b_re;
  logic [4:0] b_waddr;
  logic [1:0] b_wdata;
  logic [2:0] b_raddr;
  logic [7:0] b_q;

  logic [63:0] ref_a, ref_b;
  int n_checks = 0;
  int n_errors = 0;

  msdp_ram #(.TOTAL_BITS(64), .WR_W(8), .RD_W(2), .OUT_REG(1'b1), .COMMON_CLK(1'b1),
             .COLL_MODE(msdp_pkg::COLL_OLD)) dut_i (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .wr_en(a_we), .wr_addr(a_waddr),
    .wr_data(a_wdata), .rd_en(a_re), .rd_addr(a_raddr), .rd_data(a_q));

  msdp_ram #(.TOTAL_BITS(64), .WR_W(2), .RD_W(8), .OUT_REG(1'b0), .COMMON_CLK(1'b1),
             .COLL_MODE(msdp_pkg::COLL_POISON)) dut2_i (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .wr_en(b_we), .wr_addr(b_waddr),
    .wr_data(b_wdata), .rd_en(b_re), .rd_addr(b_raddr), .rd_data(b_q));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic a_write(input int addr, input logic [7:0] d);
    @(negedge clk); a_we = 1'b1; a_waddr = 3'(addr); a_wdata = d;
    @(negedge clk); a_we = 1'b0;
    ref_a[addr*8 +: 8] = d;
  endtask

  task automatic b_write(input int addr, input logic [1:0] d);
    @(negedge clk); b_we = 1'b1; b_waddr = 5'(addr); b_wdata = d;
    @(negedge clk); b_we = 1'b0;
    ref_b[addr*2 +: 2] = d;
  endtask

  task automatic a_read(input int addr, output logic [1:0] v);
    @(negedge clk); a_re = 1'b1; a_raddr = 5'(addr);
    repeat (3) @(posedge clk);
    @(negedge clk); v = a_q; a_re = 1'b0;
  endtask

  task automatic b_read(input int addr, output logic [7:0] v);
    @(negedge clk); b_re = 1'b1; b_raddr = 3'(addr);
    repeat (2) @(posedge clk);
    @(negedge clk); v = b_q; b_re = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [1:0] va;
    logic [7:0] vb;
    a_we = 0; a_re = 0; a_waddr = 0; a_wdata = 0; a_raddr = 0;
    b_we = 0; b_re = 0; b_waddr = 0; b_wdata = 0; b_raddr = 0;
    ref_a = '0; ref_b = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 reset output A", {6'd0, a_q}, 8'h00);
    check("R7 reset output B", b_q, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 worked example
    a_write(0, 8'b0000_0001);
    for (int i = 0; i < 4; i++) begin
      a_read(i, va);
      check("R2 single-bit word", {6'd0, va}, (i == 0) ? 8'h01 : 8'h00);
    end

    // R1 full sweep, wide write / narrow read
    for (int w = 0; w < 8; w++) a_write(w, 8'((w * 59 + 23) & 255));
    for (int r = 0; r < 32; r++) begin
      a_read(r, va);
      check("R1 narrow slice", {6'd0, va}, {6'd0, ref_a[r*2 +: 2]});
    end

    // R3 full sweep, narrow write / wide read
    for (int n = 0; n < 32; n++) b_write(n, 2'(((n * 7) >> 1) + n));
    for (int r = 0; r < 8; r++) begin
      b_read(r, vb);
      check("R3 wide assembly", vb, ref_b[r*8 +: 8]);
    end

    // R5 write then immediate read
    a_write(2, 8'h5A);
    a_read(9, va);
    check("R5 fresh write seen", {6'd0, va}, {6'd0, ref_a[18 +: 2]});

    // R4 latency and R6 hold
    a_write(7, 8'hC0);
    a_read(31, va);
    check("R1 top slice", {6'd0, va}, 8'h03);
    @(negedge clk); a_re = 1'b1; a_raddr = 5'd28;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R4 not yet updated", {6'd0, a_q}, 8'h03);
    a_re = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R4 updated on third edge", {6'd0, a_q}, 8'h00);
    a_raddr = 5'd31;
    repeat (4) @(negedge clk);
    check("R6 hold with enable low", {6'd0, a_q}, 8'h00);
    b_read(2, vb);
    @(negedge clk); b_raddr = 3'd5;
    repeat (4) @(negedge clk);
    check("R6 hold with enable low B", b_q, vb);

    // R10 write enable low
    @(negedge clk); a_we = 1'b0; a_waddr = 3'd1; a_wdata = 8'hFF;
    @(negedge clk);
    for (int i = 4; i < 8; i++) begin
      a_read(i, va);
      check("R10 no write when disabled", {6'd0, va}, {6'd0, ref_a[i*2 +: 2]});
    end

    // R8 overlapping same-cycle read, old-data mode
    @(negedge clk); a_we = 1'b1; a_waddr = 3'd3; a_wdata = 8'h3C;
    a_re = 1'b1; a_raddr = 5'd13;
    @(posedge clk); @(negedge clk); a_we = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); a_re = 1'b0;
    check("R8 old data on collision", {6'd0, a_q}, {6'd0, ref_a[26 +: 2]});
    ref_a[24 +: 8] = 8'h3C;
    a_read(13, va);
    check("R8 new data after collision", {6'd0, va}, 8'h03);

    // R11 non-overlapping same-cycle read
    @(negedge clk); a_we = 1'b1; a_waddr = 3'd4; a_wdata = 8'h81;
    a_re = 1'b1; a_raddr = 5'd1;
    @(posedge clk); @(negedge clk); a_we = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); a_re = 1'b0;
    check("R11 disjoint read A", {6'd0, a_q}, {6'd0, ref_a[2 +: 2]});
    ref_a[32 +: 8] = 8'h81;

    // R9 overlapping same-cycle read, poison mode
    @(negedge clk); b_we = 1'b1; b_waddr = 5'd9; b_wdata = 2'b10;
    b_re = 1'b1; b_raddr = 3'd2;
    @(posedge clk); @(negedge clk); b_we = 1'b0;
    @(posedge clk); @(negedge clk); b_re = 1'b0;
    check("R9 poison on collision", b_q, 8'hFF);
    ref_b[18 +: 2] = 2'b10;
    b_read(2, vb);
    check("R9 data after collision", vb, ref_b[16 +: 8]);

    // R11 in poison mode
    @(negedge clk); b_we = 1'b1; b_waddr = 5'd0; b_wdata = 2'b11;
    b_re = 1'b1; b_raddr = 3'd6;
    @(posedge clk); @(negedge clk); b_we = 1'b0;
    @(posedge clk); @(negedge clk); b_re = 1'b0;
    check("R11 disjoint read B", b_q, ref_b[48 +: 8]);
    ref_b[0 +: 2] = 2'b11;

    // R7 enable register clears to enabled: re-reset with rd_en low
    a_write(0, 8'h0E);
    @(negedge clk); a_re = 1'b0; a_raddr = 5'd5; b_re = 1'b0; b_raddr = 3'd5;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 output cleared", {6'd0, a_q}, 8'h00);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    check("R7 first read after reset A", {6'd0, a_q}, 8'h02);
    check("R7 first read after reset B", b_q, ref_b[7:0]);

    finish_run();
  end
endmodule